// File: doc/BRIEF.md
# Card Clock Divider and Gate

This block derives the card bus clock from the controller's reference clock. A 3-bit exponent written to the rate register selects a division ratio of 2^e, from 1 up to 128, so the slowest card clock is the reference divided by 128. A control word starts and stops the clock, launches a one-cycle start-operation pulse for the command and data engines, and triggers a soft reset of the controller. A 16-bit status word reports whether the clock is running and whether a soft reset is in progress.

Start, stop and exponent changes take effect only at a low-phase boundary of the divided clock, which is the point where a divided period ends. The output therefore never carries a shortened high pulse. The enable and the divide-or-pass select pass through latches that are open only while the reference is low, so that exponent 0, where the reference itself is passed through, has no glitch either. There is no data stream in this block. All pins are plain control and status signals, with no valid/ready handshake.

Top module: `cardclk_gen`

## Requirements
- R1: With exponent e (0 to 7) in the rate register and the clock running, `card_clk_o` makes exactly 256/2^e rising edges in every 256 reference cycles, and each high pulse lasts 2^(e-1) reference cycles. For e = 0, each high pulse is the high half of a reference cycle.
- R2: A rate write is applied at the next low-phase boundary of the divided clock. Across the change, no high pulse is shorter than the shorter of the old and new nominal high widths.
- R3: Writing the control word with bit 1 (start) set and bit 0 clear starts the clock at the next boundary. Status bit 8 then reads 1, and the first high pulse has full width.
- R4: Writing the control word with bit 0 (stop) set stops the clock at the next boundary. The last high pulse has full width, `card_clk_o` then stays low, and status bit 8 reads 0.
- R5: When bits 0 and 1 are written together, stop takes priority. A stopped clock stays stopped, and a running clock stops.
- R6: A control write with bit 2 set and bit 3 clear drives `op_start_o` high for exactly the one cycle after the write. This also holds when bit 1 is set in the same write.
- R7: A control write with bit 3 set starts a soft reset. Status bit 15 reads 1 for exactly 8 cycles, starting the cycle after the write. All other bits of that write are ignored, so `op_start_o` stays low.
- R8: A soft reset returns the exponent to 0 and stops the clock at the next boundary. Both remain in that state after status bit 15 clears.
- R9: Control and rate writes made while status bit 15 is 1 have no effect. They cause no start, no start-operation pulse and no change of exponent.
- R10: After `rst_ni` is released, the status word reads 0, `card_clk_o` is low, `op_start_o` is low, and the exponent is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Control-word write strobe |
| ctl_i | input | 4 | Control word: bit 0 stop, bit 1 start, bit 2 start operation, bit 3 soft reset |
| rate_wr_i | input | 1 | Rate-register write strobe |
| rate_i | input | 3 | Divide exponent e; ratio is 2^e |
| card_clk_o | output | 1 | Gated, divided card clock |
| op_start_o | output | 1 | One-cycle start-operation pulse |
| status_o | output | 16 | Bit 8 clock running, bit 15 soft reset busy, others 0 |

## Verification
The division function is driven with a sequence of all eight exponents in a scrambled order, so that both large and small jumps between rates occur. Rising edges are counted over a fixed window, which tells the ratios apart, and the last high pulse width is measured, which separates a correct duty cycle from a counter that is off by one. The shortest high pulse seen across each rate change and each start or stop shows whether the update waited for a boundary or cut a pulse short. Stop and start are written together from both the stopped and the running state, which shows which of the two takes priority. Writes issued during a soft reset are checked by observing, after the reset ends, that the clock is still stopped and that it then runs at the undivided rate.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  localparam int CTL_W     = 4;
  localparam int CTL_STOP  = 0;
  localparam int CTL_START = 1;
  localparam int CTL_OP    = 2;
  localparam int CTL_RST   = 3;
  localparam int STAT_W    = 16;
  localparam int STAT_RUN  = 8;
  localparam int STAT_RST  = 15;
endpackage

// File: rtl/cclk_div.sv
module cclk_div #(
  parameter int EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXP_W-1:0] exp_req_i,
  output logic             bnd_o,
  output logic             ph_o,
  output logic             div_sel_o
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXP_W-1:0] exp_q;
  logic [CNT_W:0]   period;
  logic [CNT_W:0]   half;

  always_comb begin
    period    = (CNT_W+1)'(1) << exp_q;
    half      = period >> 1;
    bnd_o     = ({1'b0, cnt_q} == (period - 1'b1));
    ph_o      = (exp_q != '0) && ({1'b0, cnt_q} >= half);
    div_sel_o = (exp_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else if (bnd_o) begin
      cnt_q <= '0;
      exp_q <= exp_req_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cclk_ctl.sv
module cclk_ctl
  import cclk_pkg::*;
#(
  parameter int EXP_W      = 3,
  parameter int RST_CYCLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             rate_wr_i,
  input  logic [EXP_W-1:0] rate_i,
  input  logic             bnd_i,
  output logic [EXP_W-1:0] exp_req_o,
  output logic             run_o,
  output logic             busy_o,
  output logic             op_o
);
  localparam int RC_W = $clog2(RST_CYCLES) + 1;

  logic            stop_pend_q;
  logic            start_pend_q;
  logic [RC_W-1:0] rcnt_q;
  logic            accept;

  assign accept = ctl_wr_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o        <= 1'b0;
      stop_pend_q  <= 1'b0;
      start_pend_q <= 1'b0;
      busy_o       <= 1'b0;
      rcnt_q       <= '0;
      op_o         <= 1'b0;
      exp_req_o    <= '0;
    end else begin
      op_o <= accept && ctl_i[CTL_OP] && !ctl_i[CTL_RST];

      if (bnd_i) begin
        if (stop_pend_q)       run_o <= 1'b0;
        else if (start_pend_q) run_o <= 1'b1;
      end

      if (accept && ctl_i[CTL_RST]) begin
        busy_o       <= 1'b1;
        rcnt_q       <= '0;
        exp_req_o    <= '0;
        stop_pend_q  <= 1'b1;
        start_pend_q <= 1'b0;
      end else begin
        if (busy_o) begin
          rcnt_q <= rcnt_q + 1'b1;
          if (rcnt_q == RC_W'(RST_CYCLES - 1)) busy_o <= 1'b0;
        end
        if (rate_wr_i && !busy_o) exp_req_o <= rate_i;
        if (accept && (ctl_i[CTL_STOP] || ctl_i[CTL_START])) begin
          stop_pend_q  <= ctl_i[CTL_STOP];
          start_pend_q <= !ctl_i[CTL_STOP];
        end else if (bnd_i) begin
          stop_pend_q  <= 1'b0;
          start_pend_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cclk_gate.sv
module cclk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic div_sel_i,
  input  logic ph_i,
  output logic card_clk_o
);
  logic en_l;
  logic sel_l;

  always_latch begin
    if (!rst_ni) begin
      en_l  = 1'b0;
      sel_l = 1'b0;
    end else if (!clk_i) begin
      en_l  = run_i;
      sel_l = div_sel_i;
    end
  end

  assign card_clk_o = en_l & (sel_l ? ph_i : clk_i);
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cclk_pkg::*;
#(
  parameter int EXP_W      = 3,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic              rate_wr_i,
  input  logic [EXP_W-1:0]  rate_i,
  output logic              card_clk_o,
  output logic              op_start_o,
  output logic [STAT_W-1:0] status_o
);
  logic             bnd;
  logic             ph;
  logic             div_sel;
  logic             run;
  logic             busy;
  logic [EXP_W-1:0] exp_req;

  cclk_ctl #(.EXP_W(EXP_W), .RST_CYCLES(RST_CYCLES)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_wr_i  (ctl_wr_i),
    .ctl_i     (ctl_i),
    .rate_wr_i (rate_wr_i),
    .rate_i    (rate_i),
    .bnd_i     (bnd),
    .exp_req_o (exp_req),
    .run_o     (run),
    .busy_o    (busy),
    .op_o      (op_start_o)
  );

  cclk_div #(.EXP_W(EXP_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exp_req_i (exp_req),
    .bnd_o     (bnd),
    .ph_o      (ph),
    .div_sel_o (div_sel)
  );

  cclk_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .div_sel_i  (div_sel),
    .ph_i       (ph),
    .card_clk_o (card_clk_o)
  );

  always_comb begin
    status_o           = '0;
    status_o[STAT_RUN] = run;
    status_o[STAT_RST] = busy;
  end
endmodule

// File: rtl/cardclk_chk.sv
module cardclk_chk #(
  parameter int EXP_W      = 3,
  parameter int RST_CYCLES = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_wr_i,
  input logic [3:0]       ctl_i,
  input logic             card_clk_o,
  input logic             op_start_o,
  input logic [15:0]      status_o
);
  localparam int BL_W = $clog2(RST_CYCLES + 2) + 1;
  logic [BL_W-1:0] busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_len <= '0;
    else if (status_o[15]) busy_len <= busy_len + 1'b1;
    else                  busy_len <= '0;
  end

  AST_OP_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> $past(ctl_wr_i && ctl_i[2] && !ctl_i[3] && !status_o[15])); // R6

  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && ctl_i[0] && !ctl_i[3] && !status_o[15]) |=> !$rose(status_o[8])); // R5

  AST_RUN_EDGE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_o[8]) |=> !card_clk_o); // R4

  AST_BUSY_NO_LONGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_len <= BL_W'(RST_CYCLES)); // R7

  AST_BUSY_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[15]) |-> (busy_len == BL_W'(RST_CYCLES))); // R7
endmodule

bind cardclk_gen cardclk_chk #(.EXP_W(EXP_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctl_wr_i   (ctl_wr_i),
  .ctl_i      (ctl_i),
  .card_clk_o (card_clk_o),
  .op_start_o (op_start_o),
  .status_o   (status_o)
);

// File: tb/sim_cardclk_gen.sv
`timescale 1ns/1ps
module sim_cardclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [3:0]  ctl = '0;
  logic        rate_wr = 1'b0;
  logic [2:0]  rate = '0;
  logic        card_clk;
  logic        op_start;
  logic [15:0] status;

  int  checks = 0;
  int  errors = 0;
  int  edge_cnt = 0;
  real t_rise = 0.0;
  real last_hi = 0.0;
  real min_hi = 1.0e9;

  localparam logic [2:0] VEC_E [8] = '{3'd3, 3'd0, 3'd7, 3'd1, 3'd5, 3'd2, 3'd6, 3'd4};
  localparam int         VEC_N [8] = '{32, 256, 2, 128, 8, 64, 4, 16};

  always #4 clk = ~clk;

  cardclk_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .ctl_i(ctl),
    .rate_wr_i(rate_wr), .rate_i(rate), .card_clk_o(card_clk),
    .op_start_o(op_start), .status_o(status)
  );

  always @(posedge card_clk) begin
    edge_cnt++;
    t_rise = $realtime;
  end
  always @(negedge card_clk) begin
    last_hi = $realtime - t_rise;
    if (last_hi < min_hi) min_hi = last_hi;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [3:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl = v;
    @(negedge clk); ctl_wr = 1'b0; ctl = '0;
  endtask

  task automatic write_rate(input logic [2:0] v);
    @(negedge clk); rate_wr = 1'b1; rate = v;
    @(negedge clk); rate_wr = 1'b0;
  endtask

  function automatic int ps(input real t);
    return int'(t * 1000.0);
  endfunction

  task automatic count_window(output int n);
    @(negedge clk);
    edge_cnt = 0;
    repeat (256) @(negedge clk);
    n = edge_cnt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int prev_e;
    int bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R10: quiet state after reset
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (status != 16'h0 || op_start || card_clk) bad++;
    end
    check(bad == 0 && edge_cnt == 0, "R10 reset state", bad + edge_cnt, 0);

    // R6 / R3: start and operation in one write
    write_ctl(4'b0110);
    check(op_start == 1'b1, "R6 op pulse high", op_start, 1);
    @(negedge clk);
    check(op_start == 1'b0, "R6 op pulse one cycle", op_start, 0);
    repeat (5) @(negedge clk);
    check(status[8] == 1'b1, "R3 running after start", status[8], 1);
    count_window(n);
    check(n == 256, "R1 exponent 0 rate", n, 256);

    // R1 / R2: table of exponents
    prev_e = 0;
    for (int i = 0; i < 8; i++) begin
      int e;
      int wmin;
      e = VEC_E[i];
      min_hi = 1.0e9;
      write_rate(VEC_E[i]);
      repeat (300) @(negedge clk);
      count_window(n);
      check(n == VEC_N[i], "R1 edge count", n, VEC_N[i]);
      check(ps(last_hi) == 4000 * (1 << e), "R1 high width", ps(last_hi), 4000 * (1 << e));
      wmin = 4000 * (1 << ((e < prev_e) ? e : prev_e));
      check(ps(min_hi) >= wmin, "R2 no short pulse on rate change", ps(min_hi), wmin);
      prev_e = e;
    end

    // R4: stop at exponent 3
    write_rate(3'd3);
    repeat (300) @(negedge clk);
    min_hi = 1.0e9;
    write_ctl(4'b0001);
    repeat (200) @(negedge clk);
    check(status[8] == 1'b0, "R4 status after stop", status[8], 0);
    check(ps(min_hi) == 32000, "R4 last pulse full", ps(min_hi), 32000);
    edge_cnt = 0;
    repeat (200) @(negedge clk);
    check(edge_cnt == 0 && card_clk == 1'b0, "R4 held low", edge_cnt, 0);

    // R5: start and stop together while stopped
    write_ctl(4'b0011);
    repeat (200) @(negedge clk);
    check(status[8] == 1'b0 && edge_cnt == 0, "R5 stop wins when stopped", status[8], 0);

    // R3: start with full first pulse
    min_hi = 1.0e9;
    write_ctl(4'b0010);
    repeat (200) @(negedge clk);
    check(status[8] == 1'b1, "R3 running", status[8], 1);
    check(ps(min_hi) == 32000, "R3 first pulse full", ps(min_hi), 32000);

    // R5: both while running
    write_ctl(4'b0011);
    repeat (200) @(negedge clk);
    check(status[8] == 1'b0, "R5 stop wins when running", status[8], 0);

    // R7: soft reset length, other bits ignored
    write_ctl(4'b0010);
    repeat (100) @(negedge clk);
    write_ctl(4'b1110);
    check(op_start == 1'b0, "R7 op ignored with reset", op_start, 0);
    n = 0;
    while (status[15] && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == 8, "R7 busy length", n, 8);

    // R8: stopped, exponent back to 0
    repeat (300) @(negedge clk);
    check(status[8] == 1'b0, "R8 stopped after reset", status[8], 0);
    write_ctl(4'b0010);
    repeat (300) @(negedge clk);
    count_window(n);
    check(n == 256, "R8 exponent 0 after reset", n, 256);

    // R9: writes during busy ignored
    write_ctl(4'b1000);
    write_ctl(4'b0010);
    write_rate(3'd5);
    @(negedge clk); ctl_wr = 1'b1; ctl = 4'b0100;
    @(negedge clk); ctl_wr = 1'b0; ctl = '0;
    check(op_start == 1'b0, "R9 op ignored while busy", op_start, 0);
    repeat (300) @(negedge clk);
    check(status[8] == 1'b0, "R9 start ignored while busy", status[8], 0);
    write_ctl(4'b0010);
    repeat (300) @(negedge clk);
    count_window(n);
    check(n == 256, "R9 rate ignored while busy", n, 256);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule